// File: doc/BRIEF.md
# Channel-Tagged Sample Receive Queue

This block sits between a multi-channel decimator and the system bus of an audio capture path. Each time the decimator presents a sample, the queue stores a 32-bit word made of the 24-bit sample and the number of the channel it came from. Software or a DMA engine drains the words one at a time by reading a holding location on a simple register port.

The queue keeps a small set of status bits. Four of them follow the fill level as it changes: data ready, empty, full, and at-or-above the burst threshold. Two are sticky error flags: reading an empty queue and writing to a full one. Reading the status location clears the sticky flags. A set-only enable location and a clear-only disable location build an interrupt mask, and the mask can be read back. The interrupt line is high whenever an unmasked status bit is set. A separate DMA request stays high for as long as the queue holds at least one burst of words.

Top module: `pcm_rx_queue`

## Requirements
- R1: After reset the status location (0x20) reads 0x02 (only the empty bit set), the mask location (0x1C) reads 0, and irq and dma_req are low.
- R2: Each stored word holds the channel number, zero-extended, in bits 31:24 and the sample in bits 23:0. Reads of the holding location (0x0C) return the words in arrival order and remove one word per read.
- R3: The queue holds 16 words. After 16 writes the full bit (status bit 2) is set, and 16 reads return all 16 words and leave the queue empty.
- R4: A sample that arrives while 16 words are stored is dropped and sets the overrun flag (status bit 5). The stored words are unchanged.
- R5: A read of the holding location while the queue is empty returns the last word removed (0 if none since reset), sets the underrun flag (status bit 4) and leaves the fill level at zero.
- R6: Status bit 0 is set while the level is above zero, bit 1 while it is zero, bit 2 while it is 16, and bit 3 while the level is at least the burst size.
- R7: A read of the status location returns the current flags and then clears bits 4 and 5. A flag event in the same cycle as that read leaves its flag set.
- R8: Writing to the enable location (0x14) sets the mask bits that are 1 in write data bits 5:0. Writing to the disable location (0x18) clears them. The mask location (0x1C) returns the mask in bits 5:0. No other access changes the mask.
- R9: irq is high exactly when some status bit and its mask bit are both set.
- R10: dma_req is high while the level is at least chunk_size. A chunk_size of 0 is treated as 1.
- R11: Reads of unmapped offsets return 0 and leave the queue, the flags and the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A sample is presented this cycle |
| smp_chan | input | 2 | Channel number of the sample |
| smp_data | input | 24 | Sample value |
| chunk_size | input | 4 | Burst threshold in words (1, 2, 4 or 8) |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq | output | 1 | Interrupt line |
| dma_req | output | 1 | DMA burst request |

## Verification
Some properties are checked on every cycle: the level never goes above the depth, an error flag rises only after its cause (a sample arriving at a full queue, or a holding read of an empty one), a status read with no event in the same cycle clears the overrun flag, the mask changes only after an enable or disable write, and a DMA request never comes from an empty queue. Other behaviour shows only through the bench's directed scenarios: word order and tag layout, the value returned by an empty read, the exact status encodings as the level changes, interrupt gating for each mask setting, and the DMA threshold for each burst size, including zero.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam logic [7:0] OFF_HOLD = 8'h0C;
  localparam logic [7:0] OFF_EN   = 8'h14;
  localparam logic [7:0] OFF_DIS  = 8'h18;
  localparam logic [7:0] OFF_MASK = 8'h1C;
  localparam logic [7:0] OFF_STAT = 8'h20;

  localparam int ST_READY = 0;
  localparam int ST_EMPTY = 1;
  localparam int ST_FULL  = 2;
  localparam int ST_CHUNK = 3;
  localparam int ST_UDR   = 4;
  localparam int ST_OVR   = 5;
  localparam int ST_W     = 6;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  output logic             push_ok,
  output logic             pop_ok,
  output logic [DW-1:0]    head,
  output logic [LVL_W-1:0] level
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;
  logic [LVL_W-1:0] level_nx;

  assign push_ok = push && (level != LVL_W'(DEPTH));
  assign pop_ok  = pop && (level != '0);
  assign head    = mem[rd_ptr];

  always_comb begin
    wr_ptr_nx = wr_ptr;
    rd_ptr_nx = rd_ptr;
    level_nx  = level;
    if (push_ok) wr_ptr_nx = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    if (pop_ok)  rd_ptr_nx = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   level_nx = level + 1'b1;
      2'b01:   level_nx = level - 1'b1;
      default: level_nx = level;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      level  <= level_nx;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = push_ok && (wr_ptr == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem[g] <= '0;
      else if (slot_we) mem[g] <= push_data;
    end
  end
endmodule

// File: rtl/rxq_regs.sv
module rxq_regs #(
  parameter int DEPTH   = 16,
  parameter int DW      = 32,
  parameter int CHUNK_W = 4,
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int ST_W   = rxq_pkg::ST_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [CHUNK_W-1:0] chunk_size,
  input  logic             ovf_evt,
  input  logic             udf_evt,
  input  logic             rd_stat,
  input  logic             wr_en,
  input  logic             wr_dis,
  input  logic [ST_W-1:0]  wbits,
  input  logic             pop_ok,
  input  logic [DW-1:0]    head,
  output logic [ST_W-1:0]  status,
  output logic [ST_W-1:0]  mask_q,
  output logic             ovr_flag,
  output logic             udr_flag,
  output logic [DW-1:0]    last_q,
  output logic             chunk_hit
);
  import rxq_pkg::*;
  localparam int CMP_W = (LVL_W > CHUNK_W) ? LVL_W : CHUNK_W;

  logic [ST_W-1:0]  mask_nx;
  logic             ovr_nx, udr_nx;
  logic [CMP_W-1:0] eff_chunk;

  assign eff_chunk = (chunk_size == '0) ? CMP_W'(1) : CMP_W'(chunk_size);
  assign chunk_hit = CMP_W'(level) >= eff_chunk;

  always_comb begin
    status           = '0;
    status[ST_READY] = (level != '0);
    status[ST_EMPTY] = (level == '0);
    status[ST_FULL]  = (level == LVL_W'(DEPTH));
    status[ST_CHUNK] = chunk_hit;
    status[ST_UDR]   = udr_flag;
    status[ST_OVR]   = ovr_flag;
  end

  always_comb begin
    mask_nx = mask_q;
    if (wr_en)  mask_nx = mask_q | wbits;
    if (wr_dis) mask_nx = mask_q & ~wbits;
    ovr_nx = ovf_evt || (ovr_flag && !rd_stat);
    udr_nx = udf_evt || (udr_flag && !rd_stat);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      ovr_flag <= 1'b0;
      udr_flag <= 1'b0;
      last_q   <= '0;
    end else begin
      mask_q   <= mask_nx;
      ovr_flag <= ovr_nx;
      udr_flag <= udr_nx;
      if (pop_ok) last_q <= head;
    end
  end
endmodule

// File: rtl/pcm_rx_queue.sv
module pcm_rx_queue #(
  parameter int DEPTH   = 16,
  parameter int CH_W    = 2,
  parameter int SMP_W   = 24,
  parameter int DW      = 32,
  parameter int CHUNK_W = 4,
  parameter int AW      = 8,
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int TAG_W  = DW - SMP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  input  logic [CH_W-1:0]    smp_chan,
  input  logic [SMP_W-1:0]   smp_data,
  input  logic [CHUNK_W-1:0] chunk_size,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               irq,
  output logic               dma_req
);
  import rxq_pkg::*;

  logic             rd_hold, rd_stat, wr_en, wr_dis;
  logic             push_ok, pop_ok, chunk_hit;
  logic             ovr_flag, udr_flag;
  logic [DW-1:0]    head, last_q, word_in, hold_val;
  logic [LVL_W-1:0] level;
  logic [ST_W-1:0]  status, mask_q;

  assign rd_hold = bus_sel && !bus_wr && (bus_addr == AW'(OFF_HOLD));
  assign rd_stat = bus_sel && !bus_wr && (bus_addr == AW'(OFF_STAT));
  assign wr_en   = bus_sel &&  bus_wr && (bus_addr == AW'(OFF_EN));
  assign wr_dis  = bus_sel &&  bus_wr && (bus_addr == AW'(OFF_DIS));
  assign word_in = {TAG_W'(smp_chan), smp_data};

  rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(smp_valid), .push_data(word_in), .pop(rd_hold),
    .push_ok(push_ok), .pop_ok(pop_ok), .head(head), .level(level)
  );

  rxq_regs #(.DEPTH(DEPTH), .DW(DW), .CHUNK_W(CHUNK_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .level(level), .chunk_size(chunk_size),
    .ovf_evt(smp_valid && !push_ok), .udf_evt(rd_hold && !pop_ok),
    .rd_stat(rd_stat), .wr_en(wr_en), .wr_dis(wr_dis),
    .wbits(bus_wdata[ST_W-1:0]), .pop_ok(pop_ok), .head(head),
    .status(status), .mask_q(mask_q), .ovr_flag(ovr_flag), .udr_flag(udr_flag),
    .last_q(last_q), .chunk_hit(chunk_hit)
  );

  assign hold_val = (level != '0) ? head : last_q;
  assign irq      = |(status & mask_q);
  assign dma_req  = chunk_hit;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        AW'(OFF_HOLD): bus_rdata = hold_val;
        AW'(OFF_MASK): bus_rdata = DW'(mask_q);
        AW'(OFF_STAT): bus_rdata = DW'(status);
        default:       bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [LVL_W-1:0] level,
  input logic             ovr_flag,
  input logic             udr_flag,
  input logic [5:0]       mask_q,
  input logic             dma_req
);
  import rxq_pkg::*;

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  // R4
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(smp_valid && (level == LVL_W'(DEPTH))));

  // R5
  udr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(udr_flag) |-> $past(bus_sel && !bus_wr && (bus_addr == AW'(OFF_HOLD)) && (level == '0)));

  // R7
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr == AW'(OFF_STAT)) && !(smp_valid && (level == LVL_W'(DEPTH))))
    |=> !ovr_flag);

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && ((bus_addr == AW'(OFF_EN)) || (bus_addr == AW'(OFF_DIS))))
    |=> $stable(mask_q));

  // R10
  dma_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (level != '0));
endmodule

bind pcm_rx_queue rxq_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .level(level), .ovr_flag(ovr_flag), .udr_flag(udr_flag),
  .mask_q(mask_q), .dma_req(dma_req)
);

// File: tb/pcm_rx_queue_tb.sv
module pcm_rx_queue_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [1:0]  smp_chan = '0;
  logic [23:0] smp_data = '0;
  logic [3:0]  chunk_size = 4'd8;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, dma_req;
  int          n_chk = 0;
  int          n_err = 0;
  logic [31:0] rv;

  pcm_rx_queue u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .chunk_size(chunk_size), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .dma_req(dma_req)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] ch, input logic [23:0] d);
    @(negedge clk);
    smp_valid = 1'b1; smp_chan = ch; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic t_reset();
    rd(8'h20, rv); chk("R1 status", rv, 32'h02);
    rd(8'h1C, rv); chk("R1 mask", rv, 32'h0);
    #1 chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 dma", {31'b0, dma_req}, 0);
  endtask

  task automatic t_order();
    chunk_size = 4'd8;
    push(2'd1, 24'hABCDEF);
    push(2'd3, 24'h000011);
    push(2'd0, 24'h800000);
    rd(8'h20, rv); chk("R6 partial", rv, 32'h01);
    rd(8'h0C, rv); chk("R2 first", rv, 32'h01ABCDEF);
    rd(8'h0C, rv); chk("R2 second", rv, 32'h03000011);
    rd(8'h0C, rv); chk("R2 third", rv, 32'h00800000);
    rd(8'h0C, rv); chk("R5 empty read last", rv, 32'h00800000);
    rd(8'h20, rv); chk("R5 underrun flag", rv, 32'h12);
    rd(8'h20, rv); chk("R7 cleared", rv, 32'h02);
  endtask

  task automatic t_full();
    chunk_size = 4'd8;
    for (int i = 0; i < 16; i++) push(2'(i), 24'(i * 3 + 5));
    rd(8'h20, rv); chk("R3 full", rv, 32'h0D);
    push(2'd2, 24'h777777);
    rd(8'h20, rv); chk("R4 overrun", rv, 32'h2D);
    rd(8'h20, rv); chk("R7 overrun cleared", rv, 32'h0D);
    for (int i = 0; i < 16; i++) begin
      rd(8'h0C, rv);
      chk("R3 drain", rv, {6'b0, 2'(i), 24'(i * 3 + 5)});
    end
    rd(8'h20, rv); chk("R3 drained empty", rv, 32'h02);
  endtask

  task automatic t_same_cycle();
    for (int i = 0; i < 16; i++) push(2'd0, 24'(i));
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 24'h5; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h20;
    @(negedge clk);
    smp_valid = 1'b0; bus_sel = 1'b0;
    rd(8'h20, rv); chk("R7 event wins", rv[5], 1'b1);
    for (int i = 0; i < 16; i++) rd(8'h0C, rv);
    rd(8'h20, rv);
  endtask

  task automatic t_mask();
    wr(8'h14, 32'h0000_0006);
    rd(8'h1C, rv); chk("R8 enable", rv, 32'h06);
    #1 chk("R9 irq empty", {31'b0, irq}, 1);
    wr(8'h18, 32'h0000_0002);
    rd(8'h1C, rv); chk("R8 disable", rv, 32'h04);
    #1 chk("R9 irq masked", {31'b0, irq}, 0);
    wr(8'h1C, 32'h3F);
    rd(8'h1C, rv); chk("R8 other write", rv, 32'h04);
    wr(8'h18, 32'h3F);
    wr(8'h14, 32'h10);
    rd(8'h0C, rv);
    #1 chk("R9 irq underrun", {31'b0, irq}, 1);
    rd(8'h20, rv);
    #1 chk("R9 irq after clear", {31'b0, irq}, 0);
    wr(8'h18, 32'h3F);
  endtask

  task automatic t_dma();
    chunk_size = 4'd4;
    for (int i = 0; i < 3; i++) push(2'd1, 24'(i));
    #1 chk("R10 below chunk", {31'b0, dma_req}, 0);
    push(2'd1, 24'h3);
    #1 chk("R10 at chunk", {31'b0, dma_req}, 1);
    rd(8'h20, rv); chk("R6 chunk bit", rv, 32'h09);
    rd(8'h0C, rv);
    #1 chk("R10 below again", {31'b0, dma_req}, 0);
    for (int i = 0; i < 3; i++) rd(8'h0C, rv);
    chunk_size = 4'd0;
    #1 chk("R10 zero empty", {31'b0, dma_req}, 0);
    push(2'd2, 24'h9);
    #1 chk("R10 zero as one", {31'b0, dma_req}, 1);
  endtask

  task automatic t_unmapped();
    rd(8'h40, rv); chk("R11 unmapped", rv, 32'h0);
    rd(8'h20, rv); chk("R11 state kept", rv, 32'h09);
    rd(8'h0C, rv); chk("R11 word kept", rv, 32'h02000009);
    rd(8'h20, rv);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_order();
        t_full();
        t_same_cycle();
        t_mask();
        t_dma();
        t_unmapped();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule